// File: doc/BRIEF.md
# DMA channel event gating register

This block sits between the trigger sources of a 32-channel DMA controller and its event queue. Every channel can be triggered in three ways: a manual software pulse, an external event pulse, or a chained-completion pulse. Each pulse is held in a per-source pending flag. An arbiter offers one request at a time to the event queue. When the queue accepts a request, the channel's queued-status bit is set, and the channel is kept out of arbitration until that bit is cleared again. A hardware clear pulse can release the bit, for example after the engine has discarded a null or dummy request. Software can also release it through a write-one-to-clear register.

The request leaves the block on a valid/ready stream that carries the channel number and the source. A transfer happens on a cycle where `enq_valid_o` and `enq_ready_i` are both high. The offer is recomputed every cycle from the pending flags, the status bits and the clears of that cycle. While `enq_ready_i` is low, the offered channel may therefore change, for example when a lower channel gets a trigger. Nothing is consumed and no status bit is set until the handshake. Software sees the status bits through a read-only word and releases them through a write-only word on a simple register bus. The bus has one-cycle write strobes with byte enables and a read path with one cycle of latency.

Top module: `dma_evt_gate`

## Requirements
- R1: After reset, every status bit and every pending flag is 0, `enq_valid_o` is 0, `reg_rvalid_o` is 0 and `reg_rdata_o` is 0.
- R2: A pulse on `man_trig_i[c]`, `ext_evt_i[c]` or `chain_trig_i[c]` is latched in a pending flag on the clock edge where it is sampled. From the next cycle it can be offered on the stream as channel c. The accepting handshake sets status bit c, which sits at bit position c of the status word.
- R3: While status bit c is 1, channel c is never offered. Triggers for channel c stay pending and are offered once the bit has been cleared.
- R4: Among the eligible channels, the lowest-numbered one is offered. Within that channel, the source order is manual, then external, then chained, and `enq_src_o` reads 0 for manual, 1 for external and 2 for chained. Each handshake consumes exactly the one flag that was offered.
- R5: While `enq_ready_i` is 0, no status bit is set and no pending flag is consumed.
- R6: The status word is read at byte address 0x00. It is read-only, so a write to 0x00 changes nothing.
- R7: The clear word sits at byte address 0x04. A written 1 in a byte lane whose enable is set clears the matching status bit. A written 0, or a lane whose enable is off, has no effect. Reading 0x04 returns 0.
- R8: A 1 on `hw_clr_i[c]` clears status bit c at the next clock edge.
- R9: If a clear (hardware or software) for channel c occurs in the cycle where channel c would be offered, the clear wins. Channel c is not offered in that cycle, its flag is kept, and it is offered on a later cycle.
- R10: `reg_rvalid_o` is high exactly one cycle after a cycle with `reg_rd_i` high. `reg_rdata_o` then holds the word for the address that was read. An address other than 0x00 or 0x04, including an unaligned one, reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| man_trig_i | input | 32 | Manual software trigger pulses, one per channel |
| ext_evt_i | input | 32 | External event trigger pulses, one per channel |
| chain_trig_i | input | 32 | Chained trigger pulses, one per channel |
| hw_clr_i | input | 32 | Hardware status clear pulses, one per channel |
| enq_valid_o | output | 1 | A request is offered to the event queue |
| enq_ready_i | input | 1 | The event queue accepts the offered request |
| enq_ch_o | output | 5 | Channel number of the offered request |
| enq_src_o | output | 2 | Source of the offered request (0 manual, 1 external, 2 chained) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 8 | Register write byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_wbe_i | input | 4 | Register write byte enables |
| reg_rd_i | input | 1 | Register read strobe |
| reg_raddr_i | input | 8 | Register read byte address |
| reg_rdata_o | output | 32 | Register read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |

## Verification
The bench targets three bugs. If a trigger on a masked channel is dropped, that channel is never offered again after its clear. If a channel is re-offered while its bit is set, the queue gets a duplicate entry. If a set and a clear collide, a set that wins leaves the channel stuck masked, and a grant that consumes its flag anyway loses the request. A fourth case puts several channels and several sources of one channel on the same cycle: a wrong priority or a flag consumed from the wrong source shows up as a changed grant order or a missing grant. Byte-enabled clears, zero writes, writes to the status word and back-pressure are each checked: a design that got one of them wrong would release bits it should keep, or would set bits and consume flags without a handshake.

// File: rtl/dma_evt_gate_pkg.sv
package dma_evt_gate_pkg;
  localparam int NSRC = 3;
  localparam int SRC_W = $clog2(NSRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_MAN = 2'd0,
    SRC_EXT = 2'd1,
    SRC_CHN = 2'd2
  } src_e;
endpackage

// File: rtl/evt_src_latch.sv
module evt_src_latch #(
  parameter int NSRC = 3,
  parameter int NCH  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0][NCH-1:0]  trig_i,
  input  logic [NSRC-1:0][NCH-1:0]  consume_i,
  output logic [NSRC-1:0][NCH-1:0]  pend_o,
  output logic [NCH-1:0]            any_o
);
  // one flag per source per channel; a fresh pulse beats a consume
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[s] <= '0;
      else        pend_o[s] <= trig_i[s] | (pend_o[s] & ~consume_i[s]);
    end
  end

  always_comb begin
    any_o = '0;
    for (int s = 0; s < NSRC; s++) any_o = any_o | pend_o[s];
  end

  // R4: a handshake may only consume a flag that is actually pending
  assert_consume_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((consume_i & ~pend_o) == '0));
endmodule

// File: rtl/evt_lowest_arb.sv
module evt_lowest_arb #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below[i] = below[i-1] | req_i[i-1];
  end

  assign gnt_o = req_i & ~below;
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (gnt_o[i]) idx_o = idx_o | IW'(i);
  end

  // R4: at most one winner, and a winner exists whenever a request does
  assert_gnt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && (any_o == (gnt_o != '0)));
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] status_o
);
  // clear has priority over set on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o | set_i) & ~clr_i;
  end

  // R7 R8 R9: any bit cleared in a cycle reads 0 in the next one
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(clr_i)) == '0));

  // R2: a bit can only rise where a set was requested
  assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/evt_regbus.sv
module evt_regbus #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] wbe_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] sw_clr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int NBYTE = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CLEAR_ADDR  = ADDR_W'(4);

  logic [DATA_W-1:0] lane_mask;
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{wbe_i[b]}};
  end

  // writes to the status word fall through this decode and do nothing
  assign sw_clr_o = (wr_i && waddr_i == CLEAR_ADDR) ? (wdata_i & lane_mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= (raddr_i == STATUS_ADDR) ? status_i : '0;
    end
  end

  // R10: read data valid follows the strobe by exactly one cycle
  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rvalid_o);
endmodule

// File: rtl/dma_evt_gate.sv
module dma_evt_gate
  import dma_evt_gate_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int ADDR_W = 8,
  parameter int CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    man_trig_i,
  input  logic [NCH-1:0]    ext_evt_i,
  input  logic [NCH-1:0]    chain_trig_i,
  input  logic [NCH-1:0]    hw_clr_i,
  output logic              enq_valid_o,
  input  logic              enq_ready_i,
  output logic [CH_W-1:0]   enq_ch_o,
  output logic [SRC_W-1:0]  enq_src_o,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [NCH-1:0]    reg_wdata_i,
  input  logic [NCH/8-1:0]  reg_wbe_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [NCH-1:0]    reg_rdata_o,
  output logic              reg_rvalid_o
);
  logic [NSRC-1:0][NCH-1:0] trig, pend, consume;
  logic [NCH-1:0]  pend_any, status, sw_clr, clr_all, eligible, ch_gnt, set_vec;
  logic [NSRC-1:0] src_req, src_gnt;
  logic            ch_any, src_any, hs;

  assign trig[SRC_MAN] = man_trig_i;
  assign trig[SRC_EXT] = ext_evt_i;
  assign trig[SRC_CHN] = chain_trig_i;

  evt_src_latch #(.NSRC(NSRC), .NCH(NCH)) u_latch (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .consume_i(consume),
    .pend_o(pend), .any_o(pend_any)
  );

  assign clr_all  = hw_clr_i | sw_clr;
  // a channel being cleared this cycle sits out, so its clear always wins
  assign eligible = pend_any & ~status & ~clr_all;

  evt_lowest_arb #(.N(NCH), .IW(CH_W)) u_ch_arb (
    .clk(clk), .rst_n(rst_n), .req_i(eligible),
    .gnt_o(ch_gnt), .idx_o(enq_ch_o), .any_o(ch_any)
  );

  always_comb begin
    for (int s = 0; s < NSRC; s++) src_req[s] = pend[s][enq_ch_o];
  end

  evt_lowest_arb #(.N(NSRC), .IW(SRC_W)) u_src_arb (
    .clk(clk), .rst_n(rst_n), .req_i(src_req),
    .gnt_o(src_gnt), .idx_o(enq_src_o), .any_o(src_any)
  );

  assign enq_valid_o = ch_any;
  assign hs          = enq_valid_o & enq_ready_i;
  assign set_vec     = hs ? ch_gnt : '0;

  for (genvar s = 0; s < NSRC; s++) begin : g_cons
    assign consume[s] = (hs && src_gnt[s]) ? ch_gnt : '0;
  end

  evt_status_reg #(.NCH(NCH)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_all), .status_o(status)
  );

  evt_regbus #(.DATA_W(NCH), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i), .waddr_i(reg_waddr_i), .wdata_i(reg_wdata_i), .wbe_i(reg_wbe_i),
    .rd_i(reg_rd_i), .raddr_i(reg_raddr_i), .status_i(status),
    .sw_clr_o(sw_clr), .rdata_o(reg_rdata_o), .rvalid_o(reg_rvalid_o)
  );

  // R3: a queued channel is never offered
  assert_masked_no_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid_o |-> !status[enq_ch_o]);

  // R2: an accepted request shows up as a set status bit next cycle
  assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> status[$past(enq_ch_o)]);

  // R5: under back-pressure no bit rises
  assert_stall_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid_o && !enq_ready_i) |=> ((status & ~$past(status)) == '0));

  // R4: nothing eligible below the offered channel, and offered source is pending
  assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid_o |-> (((eligible & ~({NCH{1'b1}} << enq_ch_o)) == '0) && src_any));
endmodule

// File: tb/sim_dma_evt_gate.sv
`timescale 1ns/100ps
module sim_dma_evt_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] man_t = '0, ext_t = '0, chn_t = '0, hwc = '0;
  logic        ready = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wbe = '0;
  logic        enq_valid, rvalid;
  logic [4:0]  enq_ch;
  logic [1:0]  enq_src;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference model state
  bit m_pend [3][32];
  bit m_ser  [32];
  bit m_rv;
  logic [31:0] m_rd;

  always #2.5 clk = ~clk;

  dma_evt_gate u0 (
    .clk(clk), .rst_n(rst_n), .man_trig_i(man_t), .ext_evt_i(ext_t),
    .chain_trig_i(chn_t), .hw_clr_i(hwc), .enq_valid_o(enq_valid),
    .enq_ready_i(ready), .enq_ch_o(enq_ch), .enq_src_o(enq_src),
    .reg_wr_i(wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata), .reg_wbe_i(wbe),
    .reg_rd_i(rd), .reg_raddr_i(raddr), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid)
  );

  function automatic logic [31:0] clr_now();
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (wbe[b]) m[b*8 +: 8] = 8'hFF;
    return hwc | ((wr && waddr == 8'h04) ? (wdata & m) : 32'h0);
  endfunction

  task automatic offer(output bit v, output int ch, output int src);
    logic [31:0] c = clr_now();
    v = 0; ch = 0; src = 0;
    for (int i = 0; i < 32; i++) begin
      if (!v && !m_ser[i] && !c[i] && (m_pend[0][i] || m_pend[1][i] || m_pend[2][i])) begin
        v = 1; ch = i;
        for (int s = 2; s >= 0; s--) if (m_pend[s][i]) src = s;
      end
    end
  endtask

  function automatic logic [31:0] ser_word();
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[i] = m_ser[i];
    return w;
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit v; int ch, src;
    logic [31:0] c = clr_now();
    offer(v, ch, src);
    if (rd) m_rd = (raddr == 8'h00) ? ser_word() : 32'h0;
    m_rv = rd;
    for (int i = 0; i < 32; i++) begin
      if (v && ready && i == ch) begin
        m_ser[i] = 1;
        m_pend[src][i] = 0;
      end
      if (c[i]) m_ser[i] = 0;
      if (man_t[i]) m_pend[0][i] = 1;
      if (ext_t[i]) m_pend[1][i] = 1;
      if (chn_t[i]) m_pend[2][i] = 1;
    end
  endtask

  task automatic compare();
    bit v; int ch, src; bit ok;
    offer(v, ch, src);
    ok = (enq_valid === v) && (!v || (enq_ch == ch[4:0] && enq_src == src[1:0]));
    check(ok, "stream", {enq_valid, 3'b0, enq_ch, 6'b0, enq_src}, {v, 3'b0, ch[4:0], 6'b0, src[1:0]});
    ok = (rvalid === m_rv) && (!m_rv || rdata === m_rd);
    check(ok, "read", {rvalid, rdata}, {m_rv, m_rd});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1 compare();
    @(negedge clk);
    man_t = '0; ext_t = '0; chn_t = '0; hwc = '0;
    wr = 0; rd = 0; wdata = '0; wbe = '0; waddr = '0; raddr = '0;
  endtask

  task automatic rd_word(input logic [7:0] a, input logic [31:0] exp);
    rd = 1; raddr = a;
    cyc();
    check(rvalid === 1'b1 && rdata === exp, "readback", {31'b0, rvalid, rdata}, {32'h1, exp});
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    wr = 1; waddr = a; wdata = d; wbe = be;
    cyc();
  endtask

  task automatic exp_offer(input bit v, input int ch, input int src);
    #0.5;
    check(enq_valid === v && (!v || (enq_ch == ch[4:0] && enq_src == src[1:0])), "offer",
          {enq_valid, enq_ch, enq_src}, {v, ch[4:0], src[1:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_rv = 0; m_rd = '0;
    foreach (m_ser[i]) m_ser[i] = 0;
    foreach (m_pend[s, i]) m_pend[s][i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    check(enq_valid === 1'b0 && rvalid === 1'b0 && rdata === 32'h0, "reset",
          {enq_valid, rvalid, rdata}, 34'h0);
    rst_n = 1;
    cyc();
    rd_word(8'h00, 32'h0);

    // R2: each source sets its channel's bit
    tag = "R2";
    ext_t[5] = 1; cyc();
    exp_offer(1, 5, 1);
    cyc();
    man_t[0] = 1; chn_t[31] = 1; cyc();
    exp_offer(1, 0, 0);
    cyc();
    exp_offer(1, 31, 2);
    cyc();
    exp_offer(0, 0, 0);
    rd_word(8'h00, 32'h8000_0021);

    // R3: masked channel keeps its trigger pending
    tag = "R3";
    ext_t[5] = 1; cyc();
    exp_offer(0, 0, 0);
    cyc(); cyc();
    exp_offer(0, 0, 0);
    wr_word(8'h04, 32'h0000_0020, 4'hF);
    exp_offer(1, 5, 1);
    cyc();
    rd_word(8'h00, 32'h8000_0021);

    // R6: status word ignores writes
    tag = "R6";
    wr_word(8'h00, 32'hFFFF_FFFF, 4'hF);
    rd_word(8'h00, 32'h8000_0021);
    wr_word(8'h00, 32'h0, 4'hF);
    rd_word(8'h00, 32'h8000_0021);

    // R7: byte-enabled write-one-to-clear
    tag = "R7";
    wr_word(8'h04, 32'hFFFF_FFFF, 4'b0001);
    rd_word(8'h00, 32'h8000_0000);
    wr_word(8'h04, 32'h0, 4'hF);
    rd_word(8'h00, 32'h8000_0000);
    wr_word(8'h04, 32'h8000_0000, 4'b0111);
    rd_word(8'h00, 32'h8000_0000);
    rd_word(8'h04, 32'h0);
    wr_word(8'h04, 32'h8000_0000, 4'b1000);
    rd_word(8'h00, 32'h0);

    // R4: channel and source priority, one flag per grant
    tag = "R4";
    ext_t[3] = 1; chn_t[9] = 1; man_t[20] = 1;
    man_t[12] = 1; ext_t[12] = 1; chn_t[12] = 1;
    cyc();
    exp_offer(1, 3, 1);  cyc();
    exp_offer(1, 9, 2);  cyc();
    exp_offer(1, 12, 0); cyc();
    exp_offer(1, 20, 0); cyc();
    exp_offer(0, 0, 0);
    rd_word(8'h00, 32'h0010_1208);

    // R8: hardware clear releases the remaining sources of channel 12
    tag = "R8";
    hwc[12] = 1; cyc();
    exp_offer(1, 12, 1); cyc();
    exp_offer(0, 0, 0);
    hwc[12] = 1; cyc();
    exp_offer(1, 12, 2); cyc();
    exp_offer(0, 0, 0);
    hwc = 32'hFFFF_FFFF; cyc();
    rd_word(8'h00, 32'h0);

    // R5: back-pressure
    tag = "R5";
    ready = 0;
    ext_t[1] = 1; cyc();
    exp_offer(1, 1, 1);
    cyc(); cyc();
    exp_offer(1, 1, 1);
    man_t[0] = 1; cyc();
    exp_offer(1, 0, 0);
    rd_word(8'h00, 32'h0);
    ready = 1;
    cyc();
    exp_offer(1, 1, 1); cyc();
    exp_offer(0, 0, 0);
    rd_word(8'h00, 32'h0000_0003);

    // R9: clear collides with a would-be grant
    tag = "R9";
    wr_word(8'h04, 32'hFFFF_FFFF, 4'hF);
    ext_t[7] = 1; cyc();
    exp_offer(1, 7, 1);
    hwc[7] = 1;
    exp_offer(0, 0, 0);
    cyc();
    exp_offer(1, 7, 1);
    wr = 1; waddr = 8'h04; wdata = 32'h80; wbe = 4'h1;
    exp_offer(0, 0, 0);
    cyc();
    exp_offer(1, 7, 1);
    cyc();
    rd_word(8'h00, 32'h0000_0080);

    // R10: latency and unmapped reads
    tag = "R10";
    rd_word(8'h08, 32'h0);
    rd_word(8'h01, 32'h0);
    cyc();
    check(rvalid === 1'b0, "rvalid drop", {63'b0, rvalid}, 64'h0);
    rd_word(8'h00, 32'h0000_0080);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule